// File: doc/BRIEF.md
# Flash Sliced Page-Erase Sequencer

This block drives the erase side of a flash array through a simple request/ready macro interface. A page erase can be split into a series of short timed slices so the rest of the system can keep running between them. The host first arms the block with a page address and a slice length in milliseconds. After that, each "slice" command runs one partial erase on the armed page and reports whether enough erase time has built up to call the page erased. The block also provides an ordinary one-shot erase of a whole page on the same macro interface.

Every macro operation follows the same sequence. The block switches the macro out of read-only mode, issues a one-cycle start request with the page address and a cycle count, and waits for the macro to report ready. It then restores read-only mode and returns a one-cycle response with a status code and a done flag. When no sliced erase is pending, the armed-page register holds an all-ones sentinel. Slice lengths reach the macro as clock cycles, using a cycles-per-millisecond parameter, so a test environment can shrink real time.

Top module: `flash_slice_erase`

## Requirements
- R1: After reset, busy, rsp_valid and fl_req are low, fl_mode is 0 (read-only) and pend_addr holds the all-ones sentinel.
- R2: An arm (cmd_op 0) or page erase (cmd_op 2) whose address is not a multiple of PAGE_BYTES returns rsp_status 1 with rsp_done 0, issues no macro request and leaves pend_addr unchanged.
- R3: An arm or page erase whose offset from FLASH_BASE is not below PAGE_BYTES × PAGE_COUNT returns rsp_status 1 and has no other effect.
- R4: A valid arm returns rsp_status 0 with rsp_done 0, loads pend_addr with the address, stores the slice length and clears the accumulated erase time to zero.
- R5: A slice command (cmd_op 1) while pend_addr holds the sentinel returns rsp_status 2 with rsp_done 0 and issues no macro request.
- R6: A slice sets fl_mode to 2 (partial erase), then pulses fl_req with fl_page_addr equal to the armed page and fl_cycles equal to the slice length × CYC_PER_MS. The block waits for fl_ready and then returns fl_mode to 0 before it responds.
- R7: After each slice, the slice length is added to the accumulated time. The response has rsp_done 0 while the total is below FULL_ERASE_MS. Once the total reaches or passes that value, rsp_done is 1 and pend_addr returns to the sentinel.
- R8: A valid page erase sets fl_mode to 1, requests fl_cycles = FULL_ERASE_MS × CYC_PER_MS for that page, and answers with rsp_status 0 and rsp_done 1, leaving pend_addr unchanged.
- R9: Commands that arrive while busy is high produce no response and no state change.
- R10: rsp_valid is a single-cycle strobe. It never rises while busy is high, and cmd_op 3 produces no response.
- R11: busy is high from the switch out of read-only mode until read-only mode has been restored. fl_mode is 0 whenever busy is low, and fl_req is raised only while busy with a non-read-only mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 arm, 1 slice, 2 page erase, 3 none |
| cmd_addr | input | ADDR_W | Page address for arm / page erase |
| cmd_dur_ms | input | DUR_W | Slice length in ms (arm only) |
| busy | output | 1 | Macro operation in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 success, 1 bad address, 2 nothing armed |
| rsp_done | output | 1 | Erase finished |
| pend_addr | output | ADDR_W | Armed page, all ones when none |
| fl_mode | output | 2 | Macro mode: 0 read-only, 1 erase, 2 partial erase |
| fl_req | output | 1 | One-cycle start request to the macro |
| fl_page_addr | output | ADDR_W | Page address for the request |
| fl_cycles | output | CYC_W | Operation length in clock cycles |
| fl_ready | input | 1 | Macro idle and ready |

## Verification
Several properties are checked on every cycle: the mode and busy pairing, requests issued only in an erase mode, single-cycle responses that never overlap busy, and a pending address that stays put unless a response carries a change. Other behaviour can only be shown by the bench's scenarios. This covers the accumulation of slice time across commands, clearing of that time by re-arming, the exact-threshold completion, the cycle counts handed to the macro, address range and alignment rejection, and commands dropped while busy.

// File: rtl/fse_pkg.sv
package fse_pkg;
  typedef enum logic [1:0] {OP_ARM = 2'd0, OP_SLICE = 2'd1, OP_PAGE = 2'd2, OP_NONE = 2'd3} fse_op_e;
  typedef enum logic [1:0] {MODE_RO = 2'd0, MODE_ERASE = 2'd1, MODE_PARTIAL = 2'd2} fse_mode_e;
  typedef enum logic [1:0] {STS_OK = 2'd0, STS_BADADDR = 2'd1, STS_NOPEND = 2'd2} fse_status_e;
endpackage

// File: rtl/fse_addr_check.sv
module fse_addr_check #(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_BYTES = 4096,
  parameter int          PAGE_COUNT = 256,
  parameter logic [31:0] FLASH_BASE = 32'h0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ok
);
  localparam logic [63:0] SPAN = 64'(PAGE_BYTES) * 64'(PAGE_COUNT);
  localparam int PB_LOG = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] offset;
  logic              in_range;
  logic              aligned;

  assign offset   = addr - ADDR_W'(FLASH_BASE);
  assign in_range = 64'(offset) < SPAN;

  generate
    if ((PAGE_BYTES & (PAGE_BYTES - 1)) == 0) begin : g_pow2
      assign aligned = (addr[PB_LOG-1:0] == '0);
    end else begin : g_mod
      assign aligned = ((64'(addr) % 64'(PAGE_BYTES)) == 64'd0);
    end
  endgenerate

  assign ok = in_range && aligned;
endmodule

// File: rtl/fse_elapsed.sv
module fse_elapsed #(
  parameter int DUR_W         = 8,
  parameter int ELA_W         = 9,
  parameter int FULL_ERASE_MS = 85
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             add,
  input  logic [DUR_W-1:0] dur,
  output logic             reached
);
  logic [ELA_W-1:0] total_q;
  logic [ELA_W:0]   sum;

  assign sum     = {1'b0, total_q} + (ELA_W + 1)'(dur);
  assign reached = sum >= (ELA_W + 1)'(FULL_ERASE_MS);

  always_ff @(posedge clk) begin
    if (rst || clear) total_q <= '0;
    else if (add)     total_q <= sum[ELA_W-1:0];
  end
endmodule

// File: rtl/fse_seq.sv
module fse_seq
  import fse_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DUR_W         = 8,
  parameter int CYC_W         = 19,
  parameter int CYC_PER_MS    = 1000,
  parameter int FULL_ERASE_MS = 85
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DUR_W-1:0]  cmd_dur_ms,
  input  logic              addr_ok,
  input  logic              el_reached,
  output logic              el_clear,
  output logic              el_add,
  output logic [DUR_W-1:0]  dur_q,
  output logic              busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [1:0]        fl_mode,
  output logic              fl_req,
  output logic [ADDR_W-1:0] fl_page_addr,
  output logic [CYC_W-1:0]  fl_cycles,
  input  logic              fl_ready
);
  localparam logic [ADDR_W-1:0] SENTINEL = '1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT, S_FIN} state_e;
  state_e  state;
  logic    partial_q;
  fse_op_e op;

  assign op       = fse_op_e'(cmd_op);
  assign el_clear = (state == S_IDLE) && cmd_valid && (op == OP_ARM) && addr_ok;
  assign el_add   = (state == S_FIN) && partial_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      busy         <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_status   <= STS_OK;
      rsp_done     <= 1'b0;
      pend_addr    <= SENTINEL;
      dur_q        <= '0;
      fl_mode      <= MODE_RO;
      fl_req       <= 1'b0;
      fl_page_addr <= '0;
      fl_cycles    <= '0;
      partial_q    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      fl_req    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            case (op)
              OP_ARM: begin
                rsp_valid <= 1'b1;
                rsp_done  <= 1'b0;
                if (addr_ok) begin
                  rsp_status <= STS_OK;
                  pend_addr  <= cmd_addr;
                  dur_q      <= cmd_dur_ms;
                end else begin
                  rsp_status <= STS_BADADDR;
                end
              end
              OP_SLICE: begin
                if (pend_addr == SENTINEL) begin
                  rsp_valid  <= 1'b1;
                  rsp_done   <= 1'b0;
                  rsp_status <= STS_NOPEND;
                end else begin
                  busy         <= 1'b1;
                  fl_mode      <= MODE_PARTIAL;
                  partial_q    <= 1'b1;
                  fl_page_addr <= pend_addr;
                  fl_cycles    <= CYC_W'(dur_q) * CYC_W'(CYC_PER_MS);
                  state        <= S_START;
                end
              end
              OP_PAGE: begin
                if (addr_ok) begin
                  busy         <= 1'b1;
                  fl_mode      <= MODE_ERASE;
                  partial_q    <= 1'b0;
                  fl_page_addr <= cmd_addr;
                  fl_cycles    <= CYC_W'(FULL_ERASE_MS) * CYC_W'(CYC_PER_MS);
                  state        <= S_START;
                end else begin
                  rsp_valid  <= 1'b1;
                  rsp_done   <= 1'b0;
                  rsp_status <= STS_BADADDR;
                end
              end
              default: ;
            endcase
          end
        end
        S_START: begin
          fl_req <= 1'b1;
          state  <= S_WAIT;
        end
        S_WAIT: begin
          if (fl_ready && !fl_req) begin
            fl_mode <= MODE_RO;
            state   <= S_FIN;
          end
        end
        S_FIN: begin
          busy       <= 1'b0;
          rsp_valid  <= 1'b1;
          rsp_status <= STS_OK;
          rsp_done   <= partial_q ? el_reached : 1'b1;
          if (partial_q && el_reached) pend_addr <= SENTINEL;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_slice_erase.sv
module flash_slice_erase #(
  parameter int          ADDR_W        = 32,
  parameter int          PAGE_BYTES    = 4096,
  parameter int          PAGE_COUNT    = 256,
  parameter logic [31:0] FLASH_BASE    = 32'h0,
  parameter int          DUR_W         = 8,
  parameter int          FULL_ERASE_MS = 85,
  parameter int          CYC_PER_MS    = 1000,
  parameter int          CYC_W         = $clog2((FULL_ERASE_MS + 2**DUR_W) * CYC_PER_MS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DUR_W-1:0]  cmd_dur_ms,
  output logic              busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [1:0]        fl_mode,
  output logic              fl_req,
  output logic [ADDR_W-1:0] fl_page_addr,
  output logic [CYC_W-1:0]  fl_cycles,
  input  logic              fl_ready
);
  localparam int ELA_W = $clog2(FULL_ERASE_MS + 2**DUR_W);

  logic             addr_ok;
  logic             el_clear;
  logic             el_add;
  logic             el_reached;
  logic [DUR_W-1:0] dur_q;

  fse_addr_check #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PAGE_COUNT(PAGE_COUNT), .FLASH_BASE(FLASH_BASE)
  ) addr_i (
    .addr(cmd_addr), .ok(addr_ok)
  );

  fse_elapsed #(
    .DUR_W(DUR_W), .ELA_W(ELA_W), .FULL_ERASE_MS(FULL_ERASE_MS)
  ) ela_i (
    .clk(clk), .rst(rst), .clear(el_clear), .add(el_add), .dur(dur_q), .reached(el_reached)
  );

  fse_seq #(
    .ADDR_W(ADDR_W), .DUR_W(DUR_W), .CYC_W(CYC_W),
    .CYC_PER_MS(CYC_PER_MS), .FULL_ERASE_MS(FULL_ERASE_MS)
  ) seq_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_dur_ms(cmd_dur_ms), .addr_ok(addr_ok), .el_reached(el_reached),
    .el_clear(el_clear), .el_add(el_add), .dur_q(dur_q), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_done(rsp_done),
    .pend_addr(pend_addr), .fl_mode(fl_mode), .fl_req(fl_req),
    .fl_page_addr(fl_page_addr), .fl_cycles(fl_cycles), .fl_ready(fl_ready)
  );
endmodule

// File: rtl/fse_checker.sv
module fse_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic [ADDR_W-1:0] pend_addr,
  input logic [1:0]        fl_mode,
  input logic              fl_req
);
  // R6 / R11: a start request only goes out in an erase mode while busy
  p_req_in_erase_r6: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> (busy && fl_mode != 2'd0));

  // R11: read-only mode whenever idle
  p_idle_readonly_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> fl_mode == 2'd0);

  // R10: response is a single-cycle strobe
  p_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9 / R10: no response while an operation is in flight
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rsp_valid);

  // R2: armed page only moves together with a response
  p_pend_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> $stable(pend_addr));

  // R5: error responses leave the armed page untouched
  p_err_keeps_pend_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 2'd0) |-> $stable(pend_addr));
endmodule

bind flash_slice_erase fse_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .pend_addr(pend_addr), .fl_mode(fl_mode), .fl_req(fl_req)
);

// File: tb/flash_slice_erase_tb_top.sv
`timescale 1ns/1ps
module flash_slice_erase_tb_top;
  localparam int FULL = 85;
  localparam int CPM  = 2;
  localparam int DW   = 8;
  localparam int CW   = $clog2((FULL + 2**DW) * CPM + 1);
  localparam logic [31:0] SENT = 32'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd3;
  logic [31:0]   cmd_addr = '0;
  logic [DW-1:0] cmd_dur_ms = '0;
  logic          busy, rsp_valid, rsp_done, fl_req;
  logic [1:0]    rsp_status, fl_mode;
  logic [31:0]   pend_addr, fl_page_addr;
  logic [CW-1:0] fl_cycles;
  logic          fl_ready;

  always #2.5 clk = ~clk;

  flash_slice_erase #(.DUR_W(DW), .FULL_ERASE_MS(FULL), .CYC_PER_MS(CPM), .CYC_W(CW)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_dur_ms(cmd_dur_ms), .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_done(rsp_done), .pend_addr(pend_addr), .fl_mode(fl_mode), .fl_req(fl_req),
    .fl_page_addr(fl_page_addr), .fl_cycles(fl_cycles), .fl_ready(fl_ready)
  );

  // flash macro model
  int          req_cnt = 0;
  logic [1:0]  last_mode;
  logic [31:0] last_addr;
  int          last_cyc;
  int          cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      fl_ready <= 1'b1;
      cnt      <= 0;
    end else if (fl_req) begin
      fl_ready  <= 1'b0;
      cnt       <= int'(fl_cycles);
      req_cnt   <= req_cnt + 1;
      last_mode <= fl_mode;
      last_addr <= fl_page_addr;
      last_cyc  <= int'(fl_cycles);
    end else if (!fl_ready) begin
      if (cnt == 0) fl_ready <= 1'b1;
      else          cnt <= cnt - 1;
    end
  end

  int rsp_seen = 0;
  always @(negedge clk) if (!rst && rsp_valid) rsp_seen++;

  int checks = 0;
  int errors = 0;
  logic [31:0] ref_pend = SENT;
  int ref_el = 0;
  int ref_dur = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic bit addr_good(input logic [31:0] a);
    return (a % 4096 == 0) && (a < 32'h0010_0000);
  endfunction

  task automatic do_op(input int op, input logic [31:0] addr, input int dur, input string rq);
    int  exp_st, exp_mode, exp_cyc, r0, s0, waited;
    bit  exp_done, exp_req;
    logic [31:0] exp_addr;
    exp_st = 0; exp_done = 0; exp_req = 0; exp_mode = 0; exp_cyc = 0; exp_addr = '0;
    if (op == 0) begin
      if (addr_good(addr)) begin ref_pend = addr; ref_el = 0; ref_dur = dur; end
      else exp_st = 1;
    end else if (op == 1) begin
      if (ref_pend == SENT) exp_st = 2;
      else begin
        exp_req = 1; exp_mode = 2; exp_addr = ref_pend; exp_cyc = ref_dur * CPM;
        ref_el += ref_dur;
        exp_done = (ref_el >= FULL);
        if (exp_done) ref_pend = SENT;
      end
    end else if (op == 2) begin
      if (addr_good(addr)) begin
        exp_req = 1; exp_mode = 1; exp_addr = addr; exp_cyc = FULL * CPM; exp_done = 1;
      end else exp_st = 1;
    end
    r0 = req_cnt; s0 = rsp_seen;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = addr; cmd_dur_ms = DW'(dur);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3) begin
      repeat (5) @(negedge clk);
      chk(rsp_seen == s0 && req_cnt == r0, {rq, " none"}, rsp_seen - s0, 0);
      return;
    end
    waited = 0;
    while (!rsp_valid && waited < 2000) begin @(negedge clk); waited++; end
    chk(rsp_valid, {rq, " rsp"}, rsp_valid, 1);
    chk(rsp_status == 2'(exp_st), {rq, " status"}, rsp_status, exp_st);
    chk(rsp_done == exp_done, {rq, " done"}, rsp_done, exp_done);
    chk(pend_addr == ref_pend, {rq, " pend"}, pend_addr, ref_pend);
    chk(req_cnt - r0 == int'(exp_req), {rq, " reqs"}, req_cnt - r0, exp_req);
    chk(fl_mode == 2'd0 && !busy, {rq, " R11 ro"}, fl_mode, 0);
    if (exp_req) begin
      chk(last_mode == 2'(exp_mode), {rq, " R6 mode"}, last_mode, exp_mode);
      chk(last_addr == exp_addr, {rq, " R6 addr"}, last_addr, exp_addr);
      chk(last_cyc == exp_cyc, {rq, " R6 cycles"}, last_cyc, exp_cyc);
    end
    @(negedge clk);
    chk(!rsp_valid, {rq, " R10 strobe"}, rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, kind, dur, op;
    logic [31:0] a;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rsp_valid && !fl_req, "R1 idle", busy, 0);
    chk(fl_mode == 2'd0, "R1 mode", fl_mode, 0);
    chk(pend_addr == SENT, "R1 pend", pend_addr, SENT);

    do_op(1, 0, 0, "R5 nothing armed");
    do_op(0, 32'h1004, 20, "R2 arm misaligned");
    do_op(2, 32'h0000_2010, 0, "R2 erase misaligned");
    do_op(0, 32'h0010_0000, 20, "R3 arm out of range");
    do_op(2, 32'h0020_0000, 0, "R3 erase out of range");
    do_op(0, 32'h3000, 40, "R4 arm");
    do_op(1, 0, 0, "R7 slice 40");
    do_op(1, 0, 0, "R7 slice 80");
    do_op(0, 32'h5000, 30, "R4 rearm clears");
    do_op(1, 0, 0, "R7 slice 30");
    do_op(1, 0, 0, "R7 slice 60");
    do_op(1, 0, 0, "R7 slice 90 done");
    do_op(1, 0, 0, "R5 after done");
    do_op(0, 32'h000F_F000, 17, "R4 last page");
    for (int i = 0; i < 5; i++) do_op(1, 0, 0, "R7 exact threshold");
    do_op(0, 32'h8000, 85, "R4 arm full");
    do_op(2, 32'h000F_F000, 0, "R8 page erase");
    do_op(1, 0, 0, "R7 one slice done");
    do_op(3, 32'h4000, 5, "R10 op3");

    // R9: command during busy ignored
    do_op(0, 32'h6000, 20, "R9 arm");
    s0 = rsp_seen;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R11 busy during slice", busy, 1);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 32'h7000; cmd_dur_ms = 8'd50;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (100) @(negedge clk);
    ref_el = 20;
    chk(rsp_seen - s0 == 1, "R9 one rsp", rsp_seen - s0, 1);
    chk(pend_addr == 32'h6000, "R9 pend kept", pend_addr, 32'h6000);
    do_op(1, 0, 0, "R9 slice continues");

    // random mix
    for (int i = 0; i < 40; i++) begin
      op   = int'($urandom % 3);
      kind = int'($urandom % 4);
      a    = ($urandom % 256) * 4096;
      if (kind == 1) a = a + 1 + ($urandom % 4095);
      if (kind == 2) a = 32'h0010_0000 + ($urandom % 1000) * 4096;
      dur  = 1 + int'($urandom % 60);
      if (op == 1 && ref_pend == SENT && ($urandom % 2) == 1) begin
        do_op(0, ($urandom % 256) * 4096, dur, "R4 random arm");
      end
      do_op(op, a, dur, "R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule